// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block hands out and takes back a small pool of fixed-size packet buffer pages for an Ethernet controller. Each page holds 2048 bytes, and the default pool has four of them. The block tracks which pages are in use and keeps three short queues of page numbers. The transmit queue holds pages waiting to go out. The completion queue holds pages the transmitter has finished with. The receive queue holds pages that the receiver has filled. The buffer RAM, the frame transmitter and the frame receiver live outside this block.

Software drives the block through a byte-wide register port. It writes a 3-bit command into the top bits of the command register. It selects a page through the page-select register, and it reads allocation results and the heads of the queues. The transmitter takes pages through a valid/ready handshake. The receiver asks for a page with a single-cycle request and gets the grant and the page number back in the same cycle. An interrupt status register, a mask register and a level interrupt output complete the block.

A transmit allocation that finds no free page does not fail for good. It stays pending and completes by itself as soon as a page is released.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset, all pages are free and all queues are empty. The allocation result (address 2) reads 0, the interrupt status (address 5) reads 0x04, the mask (address 6) reads 0 and irq is low. Both queue heads read 0x80, page select (address 1) reads 0, address 0 (busy) reads 0 and the pool size (address 8) reads 4.
- R2: A write to address 0 executes the command held in bits 7:5 of the byte. The lower five bits play no part. Command 0 changes nothing.
- R3: Command 1 (allocate) takes the lowest-numbered free page. It returns that page in the allocation result and sets ALLOC (0x08). When no page is free, the result reads 0x80 and ALLOC reads 0.
- R4: A failed allocation stays pending. In the first cycle without a register write in which a page is free, it takes the lowest free page, updates the result and sets ALLOC.
- R5: Command 6 appends the page in page select to the transmit queue, and a full queue ignores it. txReqValid is high with the queue head on txReqPage while the queue holds a page and no register write is under way.
- R6: On a transmit handshake, the page is freed if autoRelease is high. Otherwise it is pushed onto the completion queue, which holds up to four pages and is read at address 3. TX (0x02) is set while the completion queue holds a page.
- R7: A write to address 5 clears the status bits given by the value ANDed with 0xD6. If bit 0x02 is set in the written value, the completion queue head is also popped. TX_EMPTY (0x04) is set again whenever the transmit queue is empty. An acknowledge cannot clear RCV (0x01) or ALLOC (0x08).
- R8: A receive request is granted when no register write is under way, no transmit allocation is pending and a page is free. The lowest free page is then allocated and appended to the receive queue, which is read at address 4, and RCV is set.
- R9: Command 3 pops the receive queue and command 4 first releases the head page and then pops. After either one, RCV stays set if pages remain and is cleared if the queue is now empty. A pop from an empty queue leaves it empty.
- R10: Command 2 frees every page, empties all three queues, cancels a pending allocation and sets the allocation result to 0. Command 7 empties the transmit and completion queues without freeing pages.
- R11: irq is high exactly when the status ANDed with the mask (address 6, read/write) is nonzero.
- R12: Address 7 reads the number of allocated pages. A queue head reads 0x80 while its queue is empty.
- R13: Command 5 releases the page named in page select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| irq | output | 1 | Level interrupt |
| txReqValid | output | 1 | A queued transmit page is offered |
| txReqPage | output | PW | Offered transmit page |
| txReqReady | input | 1 | Transmitter takes the offered page |
| autoRelease | input | 1 | Free transmitted pages instead of queuing completion |
| rxAllocReq | input | 1 | Receiver asks for a page |
| rxAllocGrant | output | 1 | Receive request granted this cycle |
| rxAllocPage | output | PW | Page given to the receiver |

## Verification
The assertions check several things on every cycle. TX_EMPTY is set whenever the transmit queue is empty, and TX is set whenever the completion queue holds a page. A pending allocation completes on the first idle cycle that has a free page. A receive grant never overtakes a pending transmit allocation, and no queue count goes past its depth. irq stays low while the mask is zero. Other behaviour only shows up across a sequence of steps, so the bench scenarios cover it:
- which page number an allocation returns;
- that the queues keep their order;
- that the fifth append to a full queue is dropped;
- how the receive flag behaves on successive pops;
- that a pop from an empty queue causes no underflow.

// File: rtl/pkt_alloc_pkg.sv
package pkt_alloc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_ALLOC_TX  = 3'd1,
    CMD_RESET_ALL = 3'd2,
    CMD_RX_POP    = 3'd3,
    CMD_RX_FREE   = 3'd4,
    CMD_FREE_SEL  = 3'd5,
    CMD_TX_QUEUE  = 3'd6,
    CMD_TX_FLUSH  = 3'd7
  } mmuCmd_e;

  localparam logic [3:0] ADDR_CMD   = 4'd0;
  localparam logic [3:0] ADDR_SEL   = 4'd1;
  localparam logic [3:0] ADDR_ARES  = 4'd2;
  localparam logic [3:0] ADDR_DONE  = 4'd3;
  localparam logic [3:0] ADDR_RXH   = 4'd4;
  localparam logic [3:0] ADDR_INT   = 4'd5;
  localparam logic [3:0] ADDR_MASK  = 4'd6;
  localparam logic [3:0] ADDR_USED  = 4'd7;
  localparam logic [3:0] ADDR_SIZE  = 4'd8;

  localparam logic [7:0] INT_RCV      = 8'h01;
  localparam logic [7:0] INT_TX       = 8'h02;
  localparam logic [7:0] INT_TX_EMPTY = 8'h04;
  localparam logic [7:0] INT_ALLOC    = 8'h08;
  localparam logic [7:0] ACK_MASK     = 8'hD6;
  localparam logic [7:0] NO_PAGE      = 8'h80;

  localparam int Q_TX   = 0;
  localparam int Q_DONE = 1;
  localparam int Q_RX   = 2;
  localparam int NUM_Q  = 3;

  // Strobes from control to datapath, at most one cycle each
  typedef struct packed {
    logic freeAll;
    logic allocTake;
    logic rxPush;
    logic releaseSel;
    logic releaseRxHead;
    logic rxPop;
    logic txPush;
    logic txPop;
    logic txAutoFree;
    logic donePush;
    logic donePop;
    logic txQueuesClear;
  } dpStrobes_t;

endpackage

// File: rtl/page_queue.sv
module page_queue #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full,
  output logic             emptyNext
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTRW-1:0]  rdPtr, wrPtr;
  logic [CNTW-1:0]  count, countNext;
  logic             doPush, doPop;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + PTRW'(1);
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CNTW'(DEPTH));
  assign doPush   = push && !full && !clear;
  assign doPop    = pop && !empty && !clear;
  assign headData = slots[rdPtr];

  always_comb begin
    countNext = count;
    if (clear) countNext = '0;
    else if (doPush && !doPop) countNext = count + CNTW'(1);
    else if (doPop && !doPush) countNext = count - CNTW'(1);
  end
  assign emptyNext = (countNext == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      count <= countNext;
      if (clear) begin
        rdPtr <= '0;
        wrPtr <= '0;
      end else begin
        if (doPush) begin
          slots[wrPtr] <= pushData;
          wrPtr <= bump(wrPtr);
        end
        if (doPop) rdPtr <= bump(rdPtr);
      end
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNTW'(DEPTH)) else $error("queue count beyond depth");

endmodule

// File: rtl/alloc_datapath.sv
module alloc_datapath
  import pkt_alloc_pkg::*;
#(
  parameter int NPAGES = 4,
  parameter int PW     = $clog2(NPAGES),
  parameter int CW     = $clog2(NPAGES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobes_t    strb,
  input  logic [PW-1:0] selPage,
  output logic          freeAvail,
  output logic [PW-1:0] lowestFree,
  output logic [CW-1:0] usedCount,
  output logic [PW-1:0] txHead,
  output logic          txNotEmpty,
  output logic          txFull,
  output logic          txEmptyNext,
  output logic [PW-1:0] doneHead,
  output logic          doneNotEmpty,
  output logic          doneFull,
  output logic          doneNotEmptyNext,
  output logic [PW-1:0] rxHead,
  output logic          rxNotEmpty,
  output logic          rxFull,
  output logic          rxNotEmptyNext
);
  logic [NPAGES-1:0] usedMap, mapNext;

  logic          qClear     [NUM_Q];
  logic          qPush      [NUM_Q];
  logic          qPop       [NUM_Q];
  logic [PW-1:0] qIn        [NUM_Q];
  logic [PW-1:0] qHead      [NUM_Q];
  logic          qEmpty     [NUM_Q];
  logic          qFull      [NUM_Q];
  logic          qEmptyNext [NUM_Q];

  // Lowest free page and occupancy
  always_comb begin
    lowestFree = '0;
    for (int i = NPAGES - 1; i >= 0; i--)
      if (!usedMap[i]) lowestFree = PW'(i);
  end
  assign freeAvail = ~&usedMap;

  always_comb begin
    usedCount = '0;
    for (int i = 0; i < NPAGES; i++)
      usedCount = usedCount + CW'(usedMap[i]);
  end

  always_comb begin
    mapNext = usedMap;
    if (strb.releaseSel)    mapNext[selPage] = 1'b0;
    if (strb.releaseRxHead) mapNext[rxHead]  = 1'b0;
    if (strb.txAutoFree)    mapNext[txHead]  = 1'b0;
    if (strb.allocTake)     mapNext[lowestFree] = 1'b1;
    if (strb.freeAll)       mapNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) usedMap <= '0;
    else       usedMap <= mapNext;
  end

  // Queue wiring
  always_comb begin
    qClear[Q_TX]   = strb.freeAll || strb.txQueuesClear;
    qPush[Q_TX]    = strb.txPush;
    qPop[Q_TX]     = strb.txPop;
    qIn[Q_TX]      = selPage;
    qClear[Q_DONE] = strb.freeAll || strb.txQueuesClear;
    qPush[Q_DONE]  = strb.donePush;
    qPop[Q_DONE]   = strb.donePop;
    qIn[Q_DONE]    = qHead[Q_TX];
    qClear[Q_RX]   = strb.freeAll;
    qPush[Q_RX]    = strb.rxPush;
    qPop[Q_RX]     = strb.rxPop;
    qIn[Q_RX]      = lowestFree;
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : gQueue
    page_queue #(.DEPTH(NPAGES), .WIDTH(PW)) uQueue (
      .clk      (clk),
      .rstN     (rstN),
      .clear    (qClear[q]),
      .push     (qPush[q]),
      .pushData (qIn[q]),
      .pop      (qPop[q]),
      .headData (qHead[q]),
      .empty    (qEmpty[q]),
      .full     (qFull[q]),
      .emptyNext(qEmptyNext[q])
    );
  end

  assign txHead           = qHead[Q_TX];
  assign txNotEmpty       = !qEmpty[Q_TX];
  assign txFull           = qFull[Q_TX];
  assign txEmptyNext      = qEmptyNext[Q_TX];
  assign doneHead         = qHead[Q_DONE];
  assign doneNotEmpty     = !qEmpty[Q_DONE];
  assign doneFull         = qFull[Q_DONE];
  assign doneNotEmptyNext = !qEmptyNext[Q_DONE];
  assign rxHead           = qHead[Q_RX];
  assign rxNotEmpty       = !qEmpty[Q_RX];
  assign rxFull           = qFull[Q_RX];
  assign rxNotEmptyNext   = !qEmptyNext[Q_RX];

  assert_rx_push_free_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxPush |-> freeAvail) else $error("receive push without free page");

  assert_rx_release_head_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.releaseRxHead |-> rxNotEmpty) else $error("release of empty receive head");

endmodule

// File: rtl/alloc_control.sv
module alloc_control
  import pkt_alloc_pkg::*;
#(
  parameter int NPAGES = 4,
  parameter int PW     = $clog2(NPAGES),
  parameter int CW     = $clog2(NPAGES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    regAddr,
  input  logic          regWrEn,
  input  logic [7:0]    regWrData,
  output logic [7:0]    regRdData,
  output logic          irq,
  output logic          txReqValid,
  input  logic          txReqReady,
  input  logic          autoRelease,
  input  logic          rxAllocReq,
  output logic          rxAllocGrant,
  output dpStrobes_t    strb,
  output logic [PW-1:0] selPage,
  input  logic          freeAvail,
  input  logic [PW-1:0] lowestFree,
  input  logic [CW-1:0] usedCount,
  input  logic [PW-1:0] doneHead,
  input  logic          txNotEmpty,
  input  logic          txFull,
  input  logic          txEmptyNext,
  input  logic          doneNotEmpty,
  input  logic          doneFull,
  input  logic          doneNotEmptyNext,
  input  logic [PW-1:0] rxHead,
  input  logic          rxNotEmpty,
  input  logic          rxFull,
  input  logic          rxNotEmptyNext
);
  logic [7:0] allocRes, allocResNext;
  logic       allocPending, allocPendingNext;
  logic [7:0] intStat, intStatNext;
  logic [7:0] intMask;
  mmuCmd_e    cmd;
  logic       cmdWr, ackWr, idle, txShake, retryTake;

  assign cmd          = mmuCmd_e'(regWrData[7:5]);
  assign cmdWr        = regWrEn && (regAddr == ADDR_CMD);
  assign ackWr        = regWrEn && (regAddr == ADDR_INT);
  assign idle         = !regWrEn;
  assign txReqValid   = txNotEmpty && idle;
  assign txShake      = txReqValid && txReqReady;
  assign retryTake    = idle && allocPending && freeAvail;
  assign rxAllocGrant = idle && rxAllocReq && !allocPending && freeAvail && !rxFull;

  // Strobe generation
  always_comb begin
    strb = '0;
    if (cmdWr) begin
      unique case (cmd)
        CMD_ALLOC_TX:  strb.allocTake = freeAvail;
        CMD_RESET_ALL: strb.freeAll = 1'b1;
        CMD_RX_POP:    strb.rxPop = 1'b1;
        CMD_RX_FREE: begin
          strb.releaseRxHead = rxNotEmpty;
          strb.rxPop = 1'b1;
        end
        CMD_FREE_SEL:  strb.releaseSel = 1'b1;
        CMD_TX_QUEUE:  strb.txPush = !txFull;
        CMD_TX_FLUSH:  strb.txQueuesClear = 1'b1;
        default: ;
      endcase
    end
    if (ackWr && regWrData[1]) strb.donePop = 1'b1;
    if (txShake) begin
      strb.txPop = 1'b1;
      if (autoRelease) strb.txAutoFree = 1'b1;
      else             strb.donePush = !doneFull;
    end
    if (retryTake) strb.allocTake = 1'b1;
    if (rxAllocGrant) begin
      strb.allocTake = 1'b1;
      strb.rxPush = 1'b1;
    end
  end

  // Allocation result and interrupt status
  always_comb begin
    allocResNext     = allocRes;
    allocPendingNext = allocPending;
    intStatNext      = intStat;
    if (ackWr) intStatNext = intStatNext & ~(regWrData & ACK_MASK);
    if (cmdWr && cmd == CMD_ALLOC_TX) begin
      intStatNext = intStatNext & ~INT_ALLOC;
      if (freeAvail) begin
        allocResNext     = 8'(lowestFree);
        allocPendingNext = 1'b0;
        intStatNext      = intStatNext | INT_ALLOC;
      end else begin
        allocResNext     = NO_PAGE;
        allocPendingNext = 1'b1;
      end
    end
    if (cmdWr && cmd == CMD_RESET_ALL) begin
      allocResNext     = '0;
      allocPendingNext = 1'b0;
    end
    if (retryTake) begin
      allocResNext     = 8'(lowestFree);
      allocPendingNext = 1'b0;
      intStatNext      = intStatNext | INT_ALLOC;
    end
    if (rxAllocGrant) intStatNext = intStatNext | INT_RCV;
    if (cmdWr && (cmd == CMD_RX_POP || cmd == CMD_RX_FREE)) begin
      if (rxNotEmptyNext) intStatNext = intStatNext | INT_RCV;
      else                intStatNext = intStatNext & ~INT_RCV;
    end
    if (txEmptyNext)      intStatNext = intStatNext | INT_TX_EMPTY;
    if (doneNotEmptyNext) intStatNext = intStatNext | INT_TX;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allocRes     <= '0;
      allocPending <= 1'b0;
      intStat      <= INT_TX_EMPTY;
      intMask      <= '0;
      selPage      <= '0;
    end else begin
      allocRes     <= allocResNext;
      allocPending <= allocPendingNext;
      intStat      <= intStatNext;
      if (regWrEn && regAddr == ADDR_MASK) intMask <= regWrData;
      if (regWrEn && regAddr == ADDR_SEL)  selPage <= regWrData[PW-1:0];
    end
  end

  assign irq = |(intStat & intMask);

  // Register read
  always_comb begin
    unique case (regAddr)
      ADDR_SEL:  regRdData = 8'(selPage);
      ADDR_ARES: regRdData = allocRes;
      ADDR_DONE: regRdData = doneNotEmpty ? 8'(doneHead) : NO_PAGE;
      ADDR_RXH:  regRdData = rxNotEmpty ? 8'(rxHead) : NO_PAGE;
      ADDR_INT:  regRdData = intStat;
      ADDR_MASK: regRdData = intMask;
      ADDR_USED: regRdData = 8'(usedCount);
      ADDR_SIZE: regRdData = 8'(NPAGES);
      default:   regRdData = '0;
    endcase
  end

  assert_tx_empty_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    !txNotEmpty |-> intStat[2]) else $error("TX_EMPTY low with empty queue");

  assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneNotEmpty |-> intStat[1]) else $error("TX low with completion pending");

  assert_retry_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    (allocPending && freeAvail && !regWrEn) |=> (!allocPending && intStat[3]))
    else $error("pending allocation not completed");

  assert_rx_after_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxAllocGrant |-> !allocPending) else $error("receive grant ahead of pending allocation");

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rstN)
    (intMask == '0) |-> !irq) else $error("irq with zero mask");

endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pkt_alloc_pkg::*;
#(
  parameter int NPAGES = 4,
  localparam int PW    = $clog2(NPAGES),
  localparam int CW    = $clog2(NPAGES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    regAddr,
  input  logic          regWrEn,
  input  logic [7:0]    regWrData,
  output logic [7:0]    regRdData,
  output logic          irq,
  output logic          txReqValid,
  output logic [PW-1:0] txReqPage,
  input  logic          txReqReady,
  input  logic          autoRelease,
  input  logic          rxAllocReq,
  output logic          rxAllocGrant,
  output logic [PW-1:0] rxAllocPage
);
  dpStrobes_t    strb;
  logic [PW-1:0] selPage, lowestFree, txHead, doneHead, rxHead;
  logic [CW-1:0] usedCount;
  logic freeAvail, txNotEmpty, txFull, txEmptyNext;
  logic doneNotEmpty, doneFull, doneNotEmptyNext;
  logic rxNotEmpty, rxFull, rxNotEmptyNext;

  alloc_control #(.NPAGES(NPAGES), .PW(PW), .CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .txReqValid(txReqValid), .txReqReady(txReqReady), .autoRelease(autoRelease),
    .rxAllocReq(rxAllocReq), .rxAllocGrant(rxAllocGrant), .strb(strb),
    .selPage(selPage), .freeAvail(freeAvail), .lowestFree(lowestFree),
    .usedCount(usedCount), .doneHead(doneHead), .txNotEmpty(txNotEmpty),
    .txFull(txFull), .txEmptyNext(txEmptyNext), .doneNotEmpty(doneNotEmpty),
    .doneFull(doneFull), .doneNotEmptyNext(doneNotEmptyNext), .rxHead(rxHead),
    .rxNotEmpty(rxNotEmpty), .rxFull(rxFull), .rxNotEmptyNext(rxNotEmptyNext)
  );

  alloc_datapath #(.NPAGES(NPAGES), .PW(PW), .CW(CW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .selPage(selPage),
    .freeAvail(freeAvail), .lowestFree(lowestFree), .usedCount(usedCount),
    .txHead(txHead), .txNotEmpty(txNotEmpty), .txFull(txFull),
    .txEmptyNext(txEmptyNext), .doneHead(doneHead), .doneNotEmpty(doneNotEmpty),
    .doneFull(doneFull), .doneNotEmptyNext(doneNotEmptyNext), .rxHead(rxHead),
    .rxNotEmpty(rxNotEmpty), .rxFull(rxFull), .rxNotEmptyNext(rxNotEmptyNext)
  );

  assign txReqPage   = txHead;
  assign rxAllocPage = lowestFree;

endmodule

// File: tb/pkt_page_alloc_test.sv
`timescale 1ns/1ps
module pkt_page_alloc_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irq, txReqValid, txReqReady = 1'b0, autoRelease = 1'b0;
  logic       rxAllocReq = 1'b0, rxAllocGrant;
  logic [1:0] txReqPage, rxAllocPage;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  pkt_page_alloc uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .txReqValid(txReqValid), .txReqPage(txReqPage), .txReqReady(txReqReady),
    .autoRelease(autoRelease), .rxAllocReq(rxAllocReq),
    .rxAllocGrant(rxAllocGrant), .rxAllocPage(rxAllocPage)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic expectReg(input string req, input logic [3:0] a, input int exp);
    logic [7:0] v;
    rd(a, v);
    check(req, int'(v), exp);
  endtask

  task automatic tReset();
    expectReg("R1 alloc result", 4'd2, 8'h00);
    expectReg("R1 status", 4'd5, 8'h04);
    expectReg("R1 mask", 4'd6, 8'h00);
    expectReg("R1 done head", 4'd3, 8'h80);
    expectReg("R1 rx head", 4'd4, 8'h80);
    expectReg("R1 busy", 4'd0, 8'h00);
    expectReg("R1 page select", 4'd1, 8'h00);
    expectReg("R1 pool size", 4'd8, 4);
    expectReg("R12 used count", 4'd7, 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic tAlloc();
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin
      wr(4'd0, 8'h20);
      expectReg("R3 lowest free", 4'd2, i);
    end
    rd(4'd5, v);
    check("R3 ALLOC set", int'(v & 8'h08), 8'h08);
    expectReg("R12 used four", 4'd7, 4);
    wr(4'd0, 8'h3F);                      // allocate, low bits ignored (R2)
    expectReg("R3 none free", 4'd2, 8'h80);
    rd(4'd5, v);
    check("R3 ALLOC cleared", int'(v & 8'h08), 0);
    wr(4'd0, 8'h1F);                      // command 0
    expectReg("R2 nop keeps count", 4'd7, 4);
    wr(4'd1, 8'h02);
    wr(4'd0, 8'hA0);                      // R13 release page 2
    @(negedge clk);
    expectReg("R4 retry result", 4'd2, 2);
    rd(4'd5, v);
    check("R4 retry ALLOC", int'(v & 8'h08), 8'h08);
    wr(4'd5, 8'h08);
    rd(4'd5, v);
    check("R7 ack leaves ALLOC", int'(v & 8'h08), 8'h08);
    wr(4'd0, 8'h40);
    expectReg("R10 pool reset count", 4'd7, 0);
    expectReg("R10 pool reset result", 4'd2, 0);
  endtask

  task automatic tTransmit();
    logic [7:0] v;
    int got;
    int pages [4];
    wr(4'd1, 8'h00);
    wr(4'd0, 8'h20);
    wr(4'd0, 8'hC0);                      // queue page 0
    #1;
    check("R5 valid", int'(txReqValid), 1);
    check("R5 page", int'(txReqPage), 0);
    regAddr = 4'd6; regWrData = 8'h00; regWrEn = 1'b1;
    #1 check("R5 valid held off by write", int'(txReqValid), 0);
    @(negedge clk); regWrEn = 1'b0;
    wr(4'd5, 8'h04);
    expectReg("R7 TX_EMPTY acked", 4'd5, 8'h08);
    autoRelease = 1'b0; txReqReady = 1'b1;
    @(negedge clk); txReqReady = 1'b0;
    expectReg("R6 done head", 4'd3, 0);
    rd(4'd5, v);
    check("R6 TX and TX_EMPTY", int'(v & 8'h06), 8'h06);
    expectReg("R6 page kept", 4'd7, 1);
    wr(4'd5, 8'h02);
    expectReg("R7 ack pops done", 4'd3, 8'h80);
    rd(4'd5, v);
    check("R7 TX cleared", int'(v & 8'h02), 0);
    wr(4'd0, 8'hA0);
    expectReg("R13 released", 4'd7, 0);
    wr(4'd0, 8'h20);
    wr(4'd0, 8'hC0);
    autoRelease = 1'b1; txReqReady = 1'b1;
    @(negedge clk); txReqReady = 1'b0; autoRelease = 1'b0;
    expectReg("R6 auto release", 4'd7, 0);
    expectReg("R6 no completion", 4'd3, 8'h80);
    for (int i = 0; i < 5; i++) begin
      wr(4'd1, 8'(i % 4));
      wr(4'd0, 8'hC0);
    end
    got = 0;
    txReqReady = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1;
      if (txReqValid && got < 4) pages[got] = int'(txReqPage);
      if (txReqValid) got++;
      @(negedge clk);
    end
    txReqReady = 1'b0;
    check("R5 full queue drops append", got, 4);
    for (int i = 0; i < 4; i++) begin
      expectReg("R6 completion order", 4'd3, i);
      check("R5 transmit order", pages[i], i);
      wr(4'd5, 8'h02);
    end
    expectReg("R12 done empty", 4'd3, 8'h80);
    wr(4'd0, 8'hC0);
    wr(4'd0, 8'hE0);
    #1 check("R10 flush transmit", int'(txReqValid), 0);
    wr(4'd0, 8'h40);
  endtask

  task automatic rxGrab(input string req, input int expPage);
    @(negedge clk);
    rxAllocReq = 1'b1;
    #1;
    check(req, int'(rxAllocGrant), 1);
    check(req, int'(rxAllocPage), expPage);
    @(negedge clk);
    rxAllocReq = 1'b0;
  endtask

  task automatic tReceive();
    logic [7:0] v;
    rxGrab("R8 grant page 0", 0);
    expectReg("R8 rx head", 4'd4, 0);
    rd(4'd5, v);
    check("R8 RCV set", int'(v & 8'h01), 1);
    rxGrab("R8 grant page 1", 1);
    wr(4'd0, 8'h60);
    expectReg("R9 pop head", 4'd4, 1);
    rd(4'd5, v);
    check("R9 RCV kept", int'(v & 8'h01), 1);
    expectReg("R9 pop keeps pages", 4'd7, 2);
    wr(4'd0, 8'h80);
    expectReg("R9 release pop empty", 4'd4, 8'h80);
    rd(4'd5, v);
    check("R9 RCV cleared", int'(v & 8'h01), 0);
    expectReg("R9 page freed", 4'd7, 1);
    wr(4'd0, 8'h60);
    expectReg("R9 empty pop", 4'd4, 8'h80);
    rxGrab("R9 grant after empty pop", 1);
    expectReg("R9 no underflow", 4'd4, 1);
    wr(4'd5, 8'h01);
    rd(4'd5, v);
    check("R7 ack leaves RCV", int'(v & 8'h01), 1);
    wr(4'd0, 8'h20);
    wr(4'd0, 8'h20);
    wr(4'd0, 8'h20);
    expectReg("R3 pending", 4'd2, 8'h80);
    @(negedge clk);
    rxAllocReq = 1'b1;
    #1 check("R8 held by pending", int'(rxAllocGrant), 0);
    @(negedge clk); rxAllocReq = 1'b0;
    wr(4'd1, 8'h02);
    wr(4'd0, 8'hA0);
    @(negedge clk);
    expectReg("R4 retry after release", 4'd2, 2);
  endtask

  task automatic tIrq();
    logic [7:0] v;
    wr(4'd6, 8'h01);
    #1 check("R11 irq RCV", int'(irq), 1);
    expectReg("R11 mask read", 4'd6, 8'h01);
    wr(4'd6, 8'h10);
    #1 check("R11 irq masked", int'(irq), 0);
    wr(4'd6, 8'h00);
    #1 check("R11 irq off", int'(irq), 0);
    rd(4'd5, v);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tAlloc();
    tTransmit();
    tReceive();
    tIrq();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule